// File: doc/BRIEF.md
# Jog Velocity Ramp Controller

This block turns two level-held jog requests, one for each direction, into a signed velocity command for a single axis. On each tick strobe, the velocity moves toward a target by no more than the configured jog acceleration. The target is plus or minus the configured jog speed while a permitted request is held, and zero otherwise. Dropping a request for a single tick starts a ramp back toward zero. When the request returns, the axis accelerates again from whatever speed it has at that point.

Motion is gated by direction. A request is refused when it points into an active overtravel switch or past a software travel limit. Any active switch also stops jogging in both directions. The exception is a held clear-error input, which allows motion away from the tripped switch. A configuration bit disables both switch inputs. The block also integrates velocity into a position count on every tick, and the software limits are checked against that count.

Top module: `jog_ramp_ctrl`

## Requirements
- R1: After reset, `vel_cmd` and `pos_cnt` are both zero.
- R2: While only `jog_pos_req` is held and motion is permitted, each tick raises `vel_cmd` by `cfg_jog_acc` and stops exactly at +`cfg_jog_vel`.
- R3: While only `jog_neg_req` is held and motion is permitted, each tick lowers `vel_cmd` by `cfg_jog_acc` and stops exactly at -`cfg_jog_vel`.
- R4: In a clock cycle where `tick` is 0, neither `vel_cmd` nor `pos_cnt` changes.
- R5: With no request held, each tick moves `vel_cmd` toward zero by `cfg_jog_acc`, and it settles exactly at zero.
- R6: When both requests are held together, the block behaves as if neither is held.
- R7: A positive jog is refused while `pos_cnt >= cfg_lim_pos`, and a negative jog is refused while `pos_cnt <= cfg_lim_neg` (signed comparisons). A refusal that arrives during motion ramps the velocity down toward zero.
- R8: With `ot_sw_en`=1 and `clr_err`=0, an active (1) level on either switch refuses jogging in both directions.
- R9: With `ot_sw_en`=1 and `clr_err`=1, jogging away from an active switch is permitted: negative off `ot_pos_sw`, positive off `ot_neg_sw`. Jogging toward an active switch stays refused.
- R10: With `ot_sw_en`=0, both switch inputs have no effect on motion.
- R11: On each tick, `pos_cnt` becomes its old value plus the newly computed `vel_cmd`, wrapping in two's complement.
- R12: On any tick, `vel_cmd` changes by at most `cfg_jog_acc`. A reversal of direction passes continuously through zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Update strobe; one velocity and position step per tick |
| jog_pos_req | input | 1 | Level-held request to jog in the positive direction |
| jog_neg_req | input | 1 | Level-held request to jog in the negative direction |
| clr_err | input | 1 | While held, permits motion away from an active switch |
| ot_pos_sw | input | 1 | Positive overtravel switch, active high |
| ot_neg_sw | input | 1 | Negative overtravel switch, active high |
| ot_sw_en | input | 1 | 1 = switch inputs are in use, 0 = switch inputs are ignored |
| cfg_jog_vel | input | VEL_W | Jog speed magnitude |
| cfg_jog_acc | input | VEL_W | Maximum velocity change per tick |
| cfg_lim_pos | input | POS_W | Positive software limit (signed) |
| cfg_lim_neg | input | POS_W | Negative software limit (signed) |
| vel_cmd | output | VEL_W+1 | Signed velocity command |
| pos_cnt | output | POS_W | Signed integrated position |

## Verification
The hardest case to reach from the ports is a software limit crossed while the axis is moving. The position has to reach the limit through its own integration, so the bench moves the positive limit to just ahead of the current count and then holds a positive jog. The ramp-down that follows then starts in the middle of an acceleration. The clear-error escape is another case that is hard to reach. It is covered by directed steps that hold one switch active and try each direction with clear-error low and then high. A long random phase follows, with biased request levels and idle gaps between ticks.

// File: rtl/jog_pkg.sv
package jog_pkg;
    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_POS  = 2'd1,
        DIR_NEG  = 2'd2
    } jog_dir_e;
endpackage

// File: rtl/jog_dir_gate.sv
module jog_dir_gate
    import jog_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic                    req_pos,
    input  logic                    req_neg,
    input  logic                    clr_err,
    input  logic                    sw_pos,
    input  logic                    sw_neg,
    input  logic                    sw_en,
    input  logic signed [POS_W-1:0] pos_now,
    input  logic signed [POS_W-1:0] lim_pos,
    input  logic signed [POS_W-1:0] lim_neg,
    output jog_dir_e                dir
);
    logic hit_pos, hit_neg, ok_pos, ok_neg;

    always_comb begin
        hit_pos = sw_en && sw_pos;
        hit_neg = sw_en && sw_neg;
        // positive: never into its own switch, off the other only with clear-error
        ok_pos  = req_pos && !req_neg && !hit_pos && (!hit_neg || clr_err)
                  && (pos_now < lim_pos);
        ok_neg  = req_neg && !req_pos && !hit_neg && (!hit_pos || clr_err)
                  && (pos_now > lim_neg);
        if (ok_pos)      dir = DIR_POS;
        else if (ok_neg) dir = DIR_NEG;
        else             dir = DIR_NONE;
    end
endmodule

// File: rtl/jog_vel_ramp.sv
module jog_vel_ramp
    import jog_pkg::*;
#(
    parameter int VEL_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  jog_dir_e              dir,
    input  logic [VEL_W-1:0]      jog_vel,
    input  logic [VEL_W-1:0]      jog_acc,
    output logic signed [VEL_W:0] vel_q,
    output logic signed [VEL_W:0] vel_d
);
    localparam int XW = VEL_W + 2;

    typedef struct packed {
        logic signed [VEL_W:0] vel;
    } ramp_st_t;

    ramp_st_t st_d, st_q;
    logic signed [XW-1:0] tgt_x, cur_x, acc_x, diff_x;

    always_comb begin
        st_d  = st_q;
        cur_x = XW'(st_q.vel);
        acc_x = $signed({2'b00, jog_acc});
        case (dir)
            DIR_POS: tgt_x = $signed({2'b00, jog_vel});
            DIR_NEG: tgt_x = -$signed({2'b00, jog_vel});
            default: tgt_x = '0;
        endcase
        diff_x = tgt_x - cur_x;
        if (tick) begin
            if (diff_x > acc_x)       st_d.vel = (VEL_W+1)'(cur_x + acc_x);
            else if (diff_x < -acc_x) st_d.vel = (VEL_W+1)'(cur_x - acc_x);
            else                      st_d.vel = (VEL_W+1)'(tgt_x);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vel_q = st_q.vel;
    assign vel_d = st_d.vel;

    logic signed [XW-1:0] vq_x, ac_x;
    assign vq_x = XW'(vel_q);
    assign ac_x = $signed({2'b00, jog_acc});

    // R12
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((vq_x - $past(vq_x)) <= $past(ac_x)) && (($past(vq_x) - vq_x) <= $past(ac_x)));
    // R4
    vel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(vel_q));
endmodule

// File: rtl/jog_pos_accum.sv
module jog_pos_accum #(
    parameter int VEL_W = 16,
    parameter int POS_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic signed [VEL_W:0]   vel_new,
    input  logic signed [VEL_W:0]   vel_reg,
    output logic signed [POS_W-1:0] pos_q
);
    typedef struct packed {
        logic signed [POS_W-1:0] pos;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) st_d.pos = st_q.pos + POS_W'(vel_new);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_q = st_q.pos;

    // R11
    pos_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pos_q == $past(pos_q) + POS_W'(vel_reg));
    // R4
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pos_q));
endmodule

// File: rtl/jog_ramp_ctrl.sv
module jog_ramp_ctrl
    import jog_pkg::*;
#(
    parameter int VEL_W = 16,
    parameter int POS_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    jog_pos_req,
    input  logic                    jog_neg_req,
    input  logic                    clr_err,
    input  logic                    ot_pos_sw,
    input  logic                    ot_neg_sw,
    input  logic                    ot_sw_en,
    input  logic [VEL_W-1:0]        cfg_jog_vel,
    input  logic [VEL_W-1:0]        cfg_jog_acc,
    input  logic signed [POS_W-1:0] cfg_lim_pos,
    input  logic signed [POS_W-1:0] cfg_lim_neg,
    output logic signed [VEL_W:0]   vel_cmd,
    output logic signed [POS_W-1:0] pos_cnt
);
    jog_dir_e              dir;
    logic signed [VEL_W:0] vel_d;

    jog_dir_gate #(.POS_W(POS_W)) u_gate (
        .req_pos (jog_pos_req),
        .req_neg (jog_neg_req),
        .clr_err (clr_err),
        .sw_pos  (ot_pos_sw),
        .sw_neg  (ot_neg_sw),
        .sw_en   (ot_sw_en),
        .pos_now (pos_cnt),
        .lim_pos (cfg_lim_pos),
        .lim_neg (cfg_lim_neg),
        .dir     (dir)
    );

    jog_vel_ramp #(.VEL_W(VEL_W)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .dir     (dir),
        .jog_vel (cfg_jog_vel),
        .jog_acc (cfg_jog_acc),
        .vel_q   (vel_cmd),
        .vel_d   (vel_d)
    );

    jog_pos_accum #(.VEL_W(VEL_W), .POS_W(POS_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .vel_new (vel_d),
        .vel_reg (vel_cmd),
        .pos_q   (pos_cnt)
    );

    // R8
    no_push_pos_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ot_sw_en && ot_pos_sw && vel_cmd >= 0) |=> vel_cmd <= $past(vel_cmd));
    // R8
    no_push_neg_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ot_sw_en && ot_neg_sw && vel_cmd <= 0) |=> vel_cmd >= $past(vel_cmd));
    // R6
    both_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && jog_pos_req && jog_neg_req && vel_cmd >= 0) |=> vel_cmd <= $past(vel_cmd));
endmodule

// File: tb/test_jog_ramp_ctrl.sv
module test_jog_ramp_ctrl;
    localparam int VW = 16;
    localparam int PW = 32;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic rq_p = 0, rq_n = 0, clr = 0, sw_p = 0, sw_n = 0, sw_en = 1;
    logic [VW-1:0] jv = 100, ja = 30;
    logic signed [PW-1:0] lp = 100000, ln = -100000;
    logic signed [VW:0]   vel_cmd;
    logic signed [PW-1:0] pos_cnt;

    int checks = 0, errors = 0;
    int m_vel = 0;
    logic signed [PW-1:0] m_pos = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    jog_ramp_ctrl #(.VEL_W(VW), .POS_W(PW)) i_jog_ramp_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .jog_pos_req(rq_p), .jog_neg_req(rq_n), .clr_err(clr),
        .ot_pos_sw(sw_p), .ot_neg_sw(sw_n), .ot_sw_en(sw_en),
        .cfg_jog_vel(jv), .cfg_jog_acc(ja),
        .cfg_lim_pos(lp), .cfg_lim_neg(ln),
        .vel_cmd(vel_cmd), .pos_cnt(pos_cnt)
    );

    function automatic int next_vel();
        bit hp, hn, okp, okn;
        int tgt;
        hp  = sw_en && sw_p;
        hn  = sw_en && sw_n;
        okp = rq_p && !rq_n && !hp && (!hn || clr) && (m_pos < lp);
        okn = rq_n && !rq_p && !hn && (!hp || clr) && (m_pos > ln);
        tgt = okp ? int'(jv) : (okn ? -int'(jv) : 0);
        if (tgt - m_vel > int'(ja)) return m_vel + int'(ja);
        if (m_vel - tgt > int'(ja)) return m_vel - int'(ja);
        return tgt;
    endfunction

    task automatic chk_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk(string tag);
        chk_val(tag, int'(vel_cmd), m_vel);
        chk_val("R11", int'(pos_cnt), int'(m_pos));
    endtask

    task automatic step(string tag);
        @(negedge clk);
        tick  = 1'b1;
        m_vel = next_vel();
        m_pos = m_pos + PW'(m_vel);
        @(negedge clk);
        tick = 1'b0;
        chk(tag);
    endtask

    task automatic set_req(bit p, bit n);
        rq_p = p;
        rq_n = n;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_val("R1", int'(vel_cmd), 0);
        chk_val("R1", int'(pos_cnt), 0);

        set_req(1, 0);
        for (int i = 0; i < 4; i++) step("R2");
        chk_val("R2", int'(vel_cmd), 100);
        chk_val("R11", int'(pos_cnt), 280);

        repeat (3) @(negedge clk);
        chk_val("R4", int'(vel_cmd), 100);
        chk_val("R4", int'(pos_cnt), 280);

        set_req(0, 0);
        for (int i = 0; i < 4; i++) step("R5");
        chk_val("R5", int'(vel_cmd), 0);

        set_req(0, 1);
        for (int i = 0; i < 4; i++) step("R3");
        chk_val("R3", int'(vel_cmd), -100);

        set_req(1, 0);
        for (int i = 0; i < 4; i++) step("R12");
        chk_val("R12", int'(vel_cmd), 20);
        for (int i = 0; i < 4; i++) step("R12");

        set_req(1, 1);
        for (int i = 0; i < 4; i++) step("R6");
        chk_val("R6", int'(vel_cmd), 0);

        lp = m_pos;
        set_req(1, 0);
        step("R7");
        chk_val("R7", int'(vel_cmd), 0);
        lp = m_pos + 150;
        for (int i = 0; i < 8; i++) step("R7");
        chk_val("R7", int'(vel_cmd), 0);
        set_req(0, 1);
        step("R7");
        chk_val("R7", int'(vel_cmd), -30);
        set_req(0, 0);
        for (int i = 0; i < 2; i++) step("R5");
        lp = 100000;

        sw_p = 1;
        set_req(1, 0);
        step("R8");
        chk_val("R8", int'(vel_cmd), 0);
        set_req(0, 1);
        step("R8");
        chk_val("R8", int'(vel_cmd), 0);
        clr = 1;
        step("R9");
        chk_val("R9", int'(vel_cmd), -30);
        set_req(1, 0);
        for (int i = 0; i < 2; i++) step("R9");
        chk_val("R9", int'(vel_cmd), 0);
        clr = 0;
        sw_p = 0;
        sw_n = 1;
        clr = 1;
        step("R9");
        chk_val("R9", int'(vel_cmd), 30);
        clr = 0;
        set_req(0, 0);
        step("R5");

        sw_en = 0;
        sw_p = 1;
        sw_n = 1;
        set_req(1, 0);
        step("R10");
        chk_val("R10", int'(vel_cmd), 30);
        set_req(0, 0);
        for (int i = 0; i < 2; i++) step("R5");

        void'($urandom(32'd20240611));
        lp = 3000;
        ln = -3000;
        for (int i = 0; i < 500; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                rq_p = 1'($urandom_range(0, 1));
                rq_n = 1'($urandom_range(0, 4) == 0);
            end
            clr   = 1'($urandom_range(0, 3) == 0);
            sw_p  = 1'($urandom_range(0, 9) == 0);
            sw_n  = 1'($urandom_range(0, 9) == 0);
            sw_en = 1'($urandom_range(0, 4) != 0);
            if ($urandom_range(0, 15) == 0) begin
                jv = VW'($urandom_range(1, 400));
                ja = VW'($urandom_range(0, 60));
            end
            repeat ($urandom_range(0, 2)) @(negedge clk);
            step("R12");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule